// File: doc/BRIEF.md
# Exception and Interrupt Priority Arbiter

This block picks one event per decision from everything that is pending at once: one nonmaskable interrupt, a bank of maskable interrupt lines and a bank of instruction fault sources. It reports the chosen event as a vector number with a one-cycle valid strobe to the instruction sequencer. The sequencer then starts the handler. Events fall into three ranked classes. The nonmaskable interrupt ranks first, maskable interrupts rank second, and faults raised while executing an instruction rank last. Inside a class, the lowest source index wins.

The two kinds of loser are treated differently. Interrupt requests are edge-captured into latches. A losing interrupt stays latched and competes again at the next decision. Faults belong to the current instruction, so any grant throws away every pending fault. Fault capture then stays closed until the sequencer signals a handler return. After that return the instruction runs again, and any fault it still causes is raised and captured once more.

Top module: `evt_prio_arbiter`

## Requirements
- R1: After reset, grantValid is 0, grantVector is 0 and grantClass is 3 (none). All latches are clear and the block is outside a handler.
- R2: The class ranking is fixed. Nonmaskable interrupt (grantClass 0) beats maskable interrupts (grantClass 1), and maskable interrupts beat instruction faults (grantClass 2).
- R3: Within the maskable interrupt class and within the fault class, the pending source with the lowest index wins.
- R4: Vector encoding. The nonmaskable interrupt is vector 2. Maskable line i is vector 32+i. Fault sources 0 to 9 map to vectors 4, 5, 10, 11, 12, 13, 14, 17, 16 and 19 in index order. Fault source i ≥ 10 maps to 20+i.
- R5: A latched maskable interrupt takes part only while intEnable is 1. While intEnable is 0 it stays latched. The nonmaskable interrupt ignores intEnable.
- R6: A decision is made only at a clock edge where seqReady is 1 and something eligible is pending. The winner appears on grantVector and grantClass, with grantValid high, in the cycle after that edge. grantValid stays 0 in every other cycle.
- R7: An interrupt latch is set at an edge where its request is 1 and was 0 at the previous edge. A new edge overrides a grant clear that happens in the same cycle. A latch set at one edge can win at the next edge. A request held high does not set the latch again after its grant.
- R8: A losing interrupt keeps its latch. The granted interrupt's latch is cleared at the grant edge.
- R9: Every grant clears all pending faults. Fault requests are captured at edges after the block leaves the handler state, and not before. The handler state is entered at any grant. It is left at an edge where handlerRet is 1 and no grant occurs.
- R10: With nothing eligible pending, no grant occurs and no latch changes, even when seqReady is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| seqReady | input | 1 | Sequencer can accept a new event this cycle |
| intEnable | input | 1 | Enables maskable interrupts |
| nmiReq | input | 1 | Nonmaskable interrupt request, edge-sensitive |
| irqReq | input | NUM_IRQ | Maskable interrupt request lines, edge-sensitive |
| faultReq | input | NUM_FLT | Fault requests raised by the current instruction |
| handlerRet | input | 1 | Handler returned; the faulting instruction re-executes |
| grantValid | output | 1 | One-cycle strobe marking a new winner |
| grantVector | output | 8 | Vector number of the winner |
| grantClass | output | 2 | Class of the winner: 0 NMI, 1 maskable, 2 fault, 3 none |

## Verification
The assertions assume that the sequencer drives seqReady and handlerRet as clean synchronous levels. They also assume that interrupt requests are sampled only at clock edges, so a pulse that is high at no edge is invisible by design. The stimulus changes every input only on the falling clock edge. It uses fixed-seed random levels for the ready, enable, request and return inputs, and adds directed sequences for simultaneous classes, masking, held levels and nested returns. Each decision is compared against a cycle-level model of the requirements kept in the bench.

// File: rtl/evt_arb_pkg.sv
package evt_arb_pkg;

  typedef enum logic [1:0] {
    CLS_NMI   = 2'd0,
    CLS_IRQ   = 2'd1,
    CLS_FAULT = 2'd2,
    CLS_NONE  = 2'd3
  } evtClass_e;

  // strobes from control to datapath
  typedef struct packed {
    logic grant;       // take the current winner
    logic faultCapEn;  // fault requests may be captured
  } ctlStrobe_t;

  localparam logic [7:0] NMI_VECTOR = 8'd2;

  function automatic logic [7:0] faultVector(input int idx);
    case (idx)
      0: return 8'd4;
      1: return 8'd5;
      2: return 8'd10;
      3: return 8'd11;
      4: return 8'd12;
      5: return 8'd13;
      6: return 8'd14;
      7: return 8'd17;
      8: return 8'd16;
      9: return 8'd19;
      default: return 8'(20 + idx);
    endcase
  endfunction

endpackage

// File: rtl/evt_arb_datapath.sv
module evt_arb_datapath
  import evt_arb_pkg::*;
#(
  parameter int NUM_IRQ  = 4,
  parameter int NUM_FLT  = 10,
  parameter int IRQ_BASE = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctlStrobe_t         strobes,
  input  logic               intEnable,
  input  logic               nmiReq,
  input  logic [NUM_IRQ-1:0] irqReq,
  input  logic [NUM_FLT-1:0] faultReq,
  output logic               anyEligible,
  output logic               grantValid,
  output logic [7:0]         grantVector,
  output logic [1:0]         grantClass
);

  logic               nmiPrev, nmiLatch, nmiRise;
  logic [NUM_IRQ-1:0] irqPrev, irqLatch, irqRise, irqElig, irqGrantMask;
  logic [NUM_FLT-1:0] faultPend;
  evtClass_e          winClass;
  logic [7:0]         winVector;

  assign nmiRise = nmiReq & ~nmiPrev;
  assign irqRise = irqReq & ~irqPrev;
  assign irqElig = irqLatch & {NUM_IRQ{intEnable}};

  // fixed priority: scan low classes first, higher classes override
  always_comb begin
    winClass     = CLS_NONE;
    winVector    = '0;
    irqGrantMask = '0;
    for (int i = NUM_FLT - 1; i >= 0; i--) begin
      if (faultPend[i]) begin
        winClass  = CLS_FAULT;
        winVector = faultVector(i);
      end
    end
    for (int i = NUM_IRQ - 1; i >= 0; i--) begin
      if (irqElig[i]) begin
        winClass        = CLS_IRQ;
        winVector       = 8'(IRQ_BASE + i);
        irqGrantMask    = '0;
        irqGrantMask[i] = 1'b1;
      end
    end
    if (nmiLatch) begin
      winClass     = CLS_NMI;
      winVector    = NMI_VECTOR;
      irqGrantMask = '0;
    end
  end

  assign anyEligible = (winClass != CLS_NONE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      nmiPrev     <= 1'b0;
      irqPrev     <= '0;
      nmiLatch    <= 1'b0;
      irqLatch    <= '0;
      faultPend   <= '0;
      grantValid  <= 1'b0;
      grantVector <= '0;
      grantClass  <= CLS_NONE;
    end else begin
      nmiPrev    <= nmiReq;
      irqPrev    <= irqReq;
      nmiLatch   <= (nmiLatch & ~(strobes.grant & (winClass == CLS_NMI))) | nmiRise;
      irqLatch   <= (irqLatch & ~(strobes.grant ? irqGrantMask : '0)) | irqRise;
      grantValid <= strobes.grant;
      if (strobes.grant) begin
        faultPend   <= '0;
        grantVector <= winVector;
        grantClass  <= winClass;
      end else if (strobes.faultCapEn) begin
        faultPend <= faultPend | faultReq;
      end
    end
  end

  assert_nmi_first_R2: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.grant && nmiLatch) |=> (grantClass == CLS_NMI));

  assert_irq_masked_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.grant && !intEnable) |=> (grantClass != CLS_IRQ));

  assert_fault_drop_R9: assert property (@(posedge clk) disable iff (!rstN)
    strobes.grant |=> (faultPend == '0));

  for (genvar g = 0; g < NUM_IRQ; g++) begin : gIrqHold
    assert_irq_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
      (irqLatch[g] && !(strobes.grant && irqGrantMask[g])) |=> irqLatch[g]);
  end

endmodule

// File: rtl/evt_arb_control.sv
module evt_arb_control
  import evt_arb_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       seqReady,
  input  logic       anyEligible,
  input  logic       handlerRet,
  output ctlStrobe_t strobes,
  output logic       inHandler
);

  assign strobes.grant      = seqReady & anyEligible;
  assign strobes.faultCapEn = ~inHandler;

  always_ff @(posedge clk) begin
    if (!rstN)                inHandler <= 1'b0;
    else if (strobes.grant)   inHandler <= 1'b1;
    else if (handlerRet)      inHandler <= 1'b0;
  end

  assert_enter_handler_R9: assert property (@(posedge clk) disable iff (!rstN)
    (seqReady && anyEligible) |=> inHandler);

  assert_leave_handler_R9: assert property (@(posedge clk) disable iff (!rstN)
    (handlerRet && !anyEligible) |=> !inHandler);

endmodule

// File: rtl/evt_prio_arbiter.sv
module evt_prio_arbiter
  import evt_arb_pkg::*;
#(
  parameter int NUM_IRQ  = 4,
  parameter int NUM_FLT  = 10,
  parameter int IRQ_BASE = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               seqReady,
  input  logic               intEnable,
  input  logic               nmiReq,
  input  logic [NUM_IRQ-1:0] irqReq,
  input  logic [NUM_FLT-1:0] faultReq,
  input  logic               handlerRet,
  output logic               grantValid,
  output logic [7:0]         grantVector,
  output logic [1:0]         grantClass
);

  ctlStrobe_t strobes;
  logic       anyEligible;
  logic       inHandler;

  evt_arb_control uCtl (
    .clk         (clk),
    .rstN        (rstN),
    .seqReady    (seqReady),
    .anyEligible (anyEligible),
    .handlerRet  (handlerRet),
    .strobes     (strobes),
    .inHandler   (inHandler)
  );

  evt_arb_datapath #(
    .NUM_IRQ  (NUM_IRQ),
    .NUM_FLT  (NUM_FLT),
    .IRQ_BASE (IRQ_BASE)
  ) uDp (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .intEnable   (intEnable),
    .nmiReq      (nmiReq),
    .irqReq      (irqReq),
    .faultReq    (faultReq),
    .anyEligible (anyEligible),
    .grantValid  (grantValid),
    .grantVector (grantVector),
    .grantClass  (grantClass)
  );

  assert_ready_gate_R6: assert property (@(posedge clk) disable iff (!rstN)
    grantValid |-> $past(seqReady));

  assert_idle_R10: assert property (@(posedge clk) disable iff (!rstN)
    !anyEligible |=> !grantValid);

endmodule

// File: tb/tb_evt_prio_arbiter.sv
module tb_evt_prio_arbiter;

  localparam int NI = 4;
  localparam int NF = 10;

  logic          clk = 1'b0;
  logic          rstN;
  logic          seqReady, intEnable, nmiReq, handlerRet;
  logic [NI-1:0] irqReq;
  logic [NF-1:0] faultReq;
  logic          grantValid;
  logic [7:0]    grantVector;
  logic [1:0]    grantClass;

  int errors = 0;
  int checks = 0;

  always #5ns clk = ~clk;

  evt_prio_arbiter #(.NUM_IRQ(NI), .NUM_FLT(NF), .IRQ_BASE(32)) dut (
    .clk(clk), .rstN(rstN), .seqReady(seqReady), .intEnable(intEnable),
    .nmiReq(nmiReq), .irqReq(irqReq), .faultReq(faultReq),
    .handlerRet(handlerRet), .grantValid(grantValid),
    .grantVector(grantVector), .grantClass(grantClass)
  );

  // model state
  logic          mNmiL, mNmiPrev, mInH;
  logic [NI-1:0] mIrqL, mIrqPrev;
  logic [NF-1:0] mFlt;
  logic          expValid;
  logic [7:0]    expVec;
  logic [1:0]    expCls;

  function automatic logic [7:0] refFaultVec(input int i);
    logic [7:0] tbl [10] = '{8'd4, 8'd5, 8'd10, 8'd11, 8'd12, 8'd13, 8'd14, 8'd17, 8'd16, 8'd19};
    if (i < 10) return tbl[i];
    return 8'(20 + i);
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic clearInputs();
    seqReady = 0; intEnable = 0; nmiReq = 0; handlerRet = 0;
    irqReq = '0; faultReq = '0;
  endtask

  task automatic doReset();
    rstN = 0;
    clearInputs();
    repeat (3) @(negedge clk);
    rstN = 1;
    mNmiL = 0; mNmiPrev = 0; mInH = 0; mIrqL = '0; mIrqPrev = '0; mFlt = '0;
    expValid = 0; expVec = 0; expCls = 2'd3;
  endtask

  // inputs already driven (at negedge); advance one edge and compare
  task automatic step(input string tag);
    int            cls = 3;
    logic [7:0]    vec = 0;
    logic [NI-1:0] irqClr = '0;
    logic          nmiClr = 0;
    logic          grant;
    if (seqReady) begin
      if (mNmiL) begin cls = 0; vec = 8'd2; nmiClr = 1; end
      else begin
        for (int i = 0; i < NI; i++)
          if (cls == 3 && intEnable && mIrqL[i]) begin cls = 1; vec = 8'(32 + i); irqClr[i] = 1; end
        for (int i = 0; i < NF; i++)
          if (cls == 3 && mFlt[i]) begin cls = 2; vec = refFaultVec(i); end
      end
    end
    grant = (cls != 3);
    mNmiL = (mNmiL & ~nmiClr) | (nmiReq & ~mNmiPrev);
    mIrqL = (mIrqL & ~irqClr) | (irqReq & ~mIrqPrev);
    if (grant) mFlt = '0;
    else if (!mInH) mFlt = mFlt | faultReq;
    mInH = grant ? 1'b1 : (handlerRet ? 1'b0 : mInH);
    mNmiPrev = nmiReq;
    mIrqPrev = irqReq;
    expValid = grant;
    if (grant) begin expVec = vec; expCls = 2'(cls); end
    @(posedge clk);
    @(negedge clk);
    check(tag, grantValid, expValid, "grantValid");
    if (expValid) begin
      check(tag, grantVector, expVec, "grantVector");
      check(tag, grantClass, expCls, "grantClass");
    end
  endtask

  initial begin
    #2ms;
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rstN = 0;
    clearInputs();
    doReset();

    // R1: reset state
    check("R1", grantValid, 0, "grantValid");
    check("R1", grantVector, 0, "grantVector");
    check("R1", grantClass, 3, "grantClass");

    // R10: ready with nothing pending
    seqReady = 1;
    repeat (3) step("R10");

    // R2 R9: all classes at once, ready low while they latch
    seqReady = 0; intEnable = 1;
    nmiReq = 1; irqReq = 4'b0100; faultReq = 10'b0000100000;
    step("R7");
    faultReq = '0;
    step("R7");
    seqReady = 1;
    step("R2");   // NMI wins, fault dropped
    step("R8");   // IRQ2 kept and wins
    step("R9");   // fault gone
    handlerRet = 1; step("R9"); handlerRet = 0;
    step("R7");   // held levels do not re-latch
    nmiReq = 0; irqReq = '0;
    step("R10");

    // R3 R4: lowest fault index, vector table
    for (int f = NF - 1; f >= 0; f--) begin
      seqReady = 0; faultReq = '0; faultReq[f] = 1;
      if (f + 1 < NF) faultReq[NF-1] = 1;
      step("R4");
      faultReq = '0; seqReady = 1;
      step("R3");
      handlerRet = 1; step("R9"); handlerRet = 0;
    end

    // R5: masked interrupt held, NMI ignores mask
    intEnable = 0; seqReady = 1;
    irqReq = 4'b1010;
    step("R5"); step("R5");
    nmiReq = 1; step("R5"); step("R5");
    intEnable = 1;
    step("R3"); step("R8"); step("R10");
    irqReq = '0; nmiReq = 0;
    step("R10");

    // R6: ready gating
    seqReady = 0; irqReq = 4'b0001;
    step("R6"); step("R6"); step("R6");
    seqReady = 1; step("R6"); step("R6");
    irqReq = '0;

    // R9: faults blocked while in handler
    handlerRet = 0; faultReq = 10'b1;
    step("R9"); step("R9");
    handlerRet = 1; step("R9"); handlerRet = 0;
    step("R9"); step("R9");
    faultReq = '0;
    handlerRet = 1; step("R9"); handlerRet = 0;

    // random mix
    for (int c = 0; c < 3000; c++) begin
      seqReady   = ($urandom % 10) < 7;
      intEnable  = ($urandom % 4) != 0;
      handlerRet = ($urandom % 10) == 0;
      if (($urandom % 16) == 0) nmiReq = ~nmiReq;
      irqReq     = irqReq ^ NI'((($urandom % 3) == 0) ? (1 << ($urandom % NI)) : 0);
      faultReq   = (($urandom % 6) == 0) ? NF'(1 << ($urandom % NF)) | NF'(1 << ($urandom % NF)) : '0;
      step("R2");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule